// File: doc/BRIEF.md
# Low MMIO Address Range Router

This block decides where a memory request that falls in the low memory-mapped I/O area is delivered. It looks at the request address and the identity of the requester and picks exactly one destination. The destination is one of six downstream ports, numbered 2 to 7, or a subtractive default port, a local fixed register block, a relocatable configuration-space window, a master abort, or a pass-through flag. The pass-through flag hands addresses outside this block's area to other decode logic.

Each downstream port owns two address windows, one for plain memory and one for prefetchable memory. Each window has an inclusive base and limit at 1 MB granularity. A per-port flag removes the prefetchable window from the low decode when it has been moved to high memory. The decode itself is combinational, and the result is registered with a valid strobe one cycle after the request.

The block also watches the programmed windows continuously. It raises a registered configuration error when two active port windows intersect, or when an active window leaves the low MMIO band.

Top module: `mmio_lo_router`

## Requirements
- R1: A request accepted on a rising edge (req_valid_i high) produces dest_valid_o high for exactly the following cycle. While dest_valid_o is low, dest_o is all zero. Reset is synchronous and active high, and it clears dest_valid_o, dest_o and config_error_o.
- R2: When valid, dest_o is one-hot. Bit k (0..5) is port k+2, bit 6 is subtractive default, bit 7 is local fixed registers, bit 8 is the configuration window, bit 9 is master abort and bit 10 is pass-through.
- R3: Address bits [31:20] give the MB number. A port window hits when base <= MB <= limit. A window whose limit is below its base is inactive and never hits.
- R4: When pf_high_i[k] is 1, the prefetchable window of port k+2 is inactive in this decode and in the error checks.
- R5: An address with TOLM <= MB < 0xFE0 that hits no active port window goes to the subtractive default port (bit 6).
- R6: MB 0xFE6 (0xFE60_0000 to 0xFE6F_FFFF) goes to local registers (bit 7) only when req_src_i equals the processor-bus ID (0). From any other requester it is master-aborted (bit 9).
- R7: Any other address with MB from 0xFE0 to 0xFEB is master-aborted (bit 9).
- R8: When cfgwin_en_i is 1, addresses with cfgwin_base_i <= MB < cfgwin_base_i + 256 go to the configuration window (bit 8), ahead of every other rule.
- R9: An address with MB below TOLM or above 0xFEB sets pass-through (bit 10).
- R10: config_error_o is 1, one cycle after the configuration is applied, when two active port windows share at least one MB.
- R11: config_error_o is 1, one cycle after the configuration is applied, when an active port window has base below TOLM or limit at or above 0xFE0.
- R12: When several active windows hit, the lowest window index wins. Window order is port 2 memory, port 2 prefetchable, port 3 memory, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request address |
| req_src_i | input | 2 | Requester ID, 0 is the processor bus |
| tolm_i | input | 12 | Bottom of low MMIO band, in MB |
| mem_base_i | input | 72 | Memory window bases, 12 bits per port, port 2 in the low bits |
| mem_limit_i | input | 72 | Memory window limits (inclusive MB) |
| pf_base_i | input | 72 | Prefetchable window bases |
| pf_limit_i | input | 72 | Prefetchable window limits (inclusive MB) |
| pf_high_i | input | 6 | Per-port: prefetchable window relocated to high MMIO |
| cfgwin_en_i | input | 1 | Configuration window enable |
| cfgwin_base_i | input | 12 | Configuration window base, in MB |
| dest_valid_o | output | 1 | Registered result strobe |
| dest_o | output | 11 | One-hot destination |
| config_error_o | output | 1 | Registered window configuration error |

## Verification
A wrong decode shows on the cycle after the request. The symptom is either the wrong one-hot bit or a vector that is not one-hot, because the result register is the only state on the request path. A stuck or mis-staged valid register shows as a strobe that lags, repeats, or carries a non-zero vector while low. Errors in the window bookkeeping appear as a wrong config_error_o one cycle after a configuration change, or as a port chosen against the stated priority when windows intersect.

// File: rtl/mmio_router_pkg.sv
package mmio_router_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned GRAN_W = 20;
  localparam int unsigned MB_W   = ADDR_W - GRAN_W;
  localparam int unsigned NPORT  = 6;
  localparam int unsigned NWIN   = 2 * NPORT;
  localparam int unsigned DEST_W = NPORT + 5;
  // destination bit positions after the port bits
  localparam int unsigned D_SUB  = NPORT;
  localparam int unsigned D_LOC  = NPORT + 1;
  localparam int unsigned D_CFG  = NPORT + 2;
  localparam int unsigned D_ABT  = NPORT + 3;
  localparam int unsigned D_PASS = NPORT + 4;
endpackage

// File: rtl/mmio_win_cmp.sv
module mmio_win_cmp #(
  parameter int unsigned MB_W    = 12,
  parameter logic [MB_W-1:0] BAND_TOP = 12'hFE0
) (
  input  logic [MB_W-1:0] base_i,
  input  logic [MB_W-1:0] limit_i,
  input  logic [MB_W-1:0] tolm_i,
  input  logic [MB_W-1:0] addr_mb_i,
  input  logic            off_i,
  output logic            en_o,
  output logic            hit_o,
  output logic            outband_o
);
  always_comb begin
    en_o      = !off_i && (limit_i >= base_i);
    hit_o     = en_o && (addr_mb_i >= base_i) && (addr_mb_i <= limit_i);
    outband_o = en_o && ((base_i < tolm_i) || (limit_i >= BAND_TOP));
  end
endmodule

// File: rtl/mmio_overlap_chk.sv
module mmio_overlap_chk #(
  parameter int unsigned NWIN = 12,
  parameter int unsigned MB_W = 12
) (
  input  logic [NWIN-1:0]      en_i,
  input  logic [NWIN*MB_W-1:0] base_i,
  input  logic [NWIN*MB_W-1:0] limit_i,
  output logic                 overlap_o
);
  always_comb begin
    overlap_o = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      for (int j = i + 1; j < NWIN; j++) begin
        if (en_i[i] && en_i[j] &&
            (base_i[i*MB_W +: MB_W] <= limit_i[j*MB_W +: MB_W]) &&
            (base_i[j*MB_W +: MB_W] <= limit_i[i*MB_W +: MB_W]))
          overlap_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmio_dest_sel.sv
module mmio_dest_sel
  import mmio_router_pkg::*;
(
  input  logic [NWIN-1:0]   hit_i,
  input  logic              cfg_hit_i,
  input  logic              in_chip_i,
  input  logic              in_fix_i,
  input  logic              is_cpu_i,
  input  logic              in_band_i,
  output logic [DEST_W-1:0] dest_o
);
  logic              any_hit;
  logic [NPORT-1:0]  port_sel;

  always_comb begin
    any_hit  = 1'b0;
    port_sel = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (hit_i[w] && !any_hit) begin
        any_hit = 1'b1;
        port_sel[w/2] = 1'b1;
      end
    end
  end

  always_comb begin
    dest_o = '0;
    if (cfg_hit_i)
      dest_o[D_CFG] = 1'b1;
    else if (in_chip_i) begin
      if (in_fix_i && is_cpu_i) dest_o[D_LOC] = 1'b1;
      else                      dest_o[D_ABT] = 1'b1;
    end else if (in_band_i) begin
      if (any_hit) dest_o[NPORT-1:0] = port_sel;
      else         dest_o[D_SUB] = 1'b1;
    end else
      dest_o[D_PASS] = 1'b1;
  end
endmodule

// File: rtl/mmio_lo_router.sv
module mmio_lo_router
  import mmio_router_pkg::*;
#(
  parameter int unsigned     SRC_W   = 2,
  parameter logic [SRC_W-1:0] CPU_SRC = '0,
  parameter int unsigned     CFG_MB  = 256,
  parameter logic [MB_W-1:0] CHIP_LO = 12'hFE0,
  parameter logic [MB_W-1:0] CHIP_HI = 12'hFEB,
  parameter logic [MB_W-1:0] FIX_LO  = 12'hFE6,
  parameter logic [MB_W-1:0] FIX_HI  = 12'hFE6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [SRC_W-1:0]      req_src_i,
  input  logic [MB_W-1:0]       tolm_i,
  input  logic [NPORT*MB_W-1:0] mem_base_i,
  input  logic [NPORT*MB_W-1:0] mem_limit_i,
  input  logic [NPORT*MB_W-1:0] pf_base_i,
  input  logic [NPORT*MB_W-1:0] pf_limit_i,
  input  logic [NPORT-1:0]      pf_high_i,
  input  logic                  cfgwin_en_i,
  input  logic [MB_W-1:0]       cfgwin_base_i,
  output logic                  dest_valid_o,
  output logic [DEST_W-1:0]     dest_o,
  output logic                  config_error_o
);
  localparam int unsigned CW_W = MB_W + 1;
  localparam logic [CW_W-1:0] CFG_SPAN = CW_W'(CFG_MB);

  logic [MB_W-1:0]      addr_mb;
  logic [NWIN*MB_W-1:0] win_base, win_limit;
  logic [NWIN-1:0]      win_en, win_hit, win_out;
  logic                 overlap, cfg_hit, in_chip, in_fix, in_band, is_cpu;
  logic [DEST_W-1:0]    dest_c;
  logic [CW_W-1:0]      cfg_end;

  assign addr_mb = req_addr_i[ADDR_W-1:GRAN_W];

  // window w: port w/2, even = memory, odd = prefetchable
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int unsigned P = w / 2;
    if (w % 2 == 0) begin : g_mem
      assign win_base[w*MB_W +: MB_W]  = mem_base_i[P*MB_W +: MB_W];
      assign win_limit[w*MB_W +: MB_W] = mem_limit_i[P*MB_W +: MB_W];
    end else begin : g_pf
      assign win_base[w*MB_W +: MB_W]  = pf_base_i[P*MB_W +: MB_W];
      assign win_limit[w*MB_W +: MB_W] = pf_limit_i[P*MB_W +: MB_W];
    end
    mmio_win_cmp #(.MB_W(MB_W), .BAND_TOP(CHIP_LO)) u_cmp (
      .base_i   (win_base[w*MB_W +: MB_W]),
      .limit_i  (win_limit[w*MB_W +: MB_W]),
      .tolm_i   (tolm_i),
      .addr_mb_i(addr_mb),
      .off_i    ((w % 2 == 1) ? pf_high_i[P] : 1'b0),
      .en_o     (win_en[w]),
      .hit_o    (win_hit[w]),
      .outband_o(win_out[w])
    );
  end

  mmio_overlap_chk #(.NWIN(NWIN), .MB_W(MB_W)) u_ovl (
    .en_i     (win_en),
    .base_i   (win_base),
    .limit_i  (win_limit),
    .overlap_o(overlap)
  );

  always_comb begin
    cfg_end = {1'b0, cfgwin_base_i} + CFG_SPAN;
    cfg_hit = cfgwin_en_i && (addr_mb >= cfgwin_base_i) && ({1'b0, addr_mb} < cfg_end);
    in_chip = (addr_mb >= CHIP_LO) && (addr_mb <= CHIP_HI);
    in_fix  = (addr_mb >= FIX_LO) && (addr_mb <= FIX_HI);
    in_band = (addr_mb >= tolm_i) && (addr_mb < CHIP_LO);
    is_cpu  = (req_src_i == CPU_SRC);
  end

  mmio_dest_sel u_sel (
    .hit_i    (win_hit),
    .cfg_hit_i(cfg_hit),
    .in_chip_i(in_chip),
    .in_fix_i (in_fix),
    .is_cpu_i (is_cpu),
    .in_band_i(in_band),
    .dest_o   (dest_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_valid_o   <= 1'b0;
      dest_o         <= '0;
      config_error_o <= 1'b0;
    end else begin
      dest_valid_o   <= req_valid_i;
      dest_o         <= req_valid_i ? dest_c : '0;
      config_error_o <= overlap | (|win_out);
    end
  end
endmodule

// File: rtl/mmio_lo_router_chk.sv
module mmio_lo_router_chk
  import mmio_router_pkg::*;
#(
  parameter int unsigned      SRC_W   = 2,
  parameter logic [SRC_W-1:0] CPU_SRC = '0,
  parameter logic [MB_W-1:0]  CHIP_LO = 12'hFE0,
  parameter logic [MB_W-1:0]  CHIP_HI = 12'hFEB,
  parameter logic [MB_W-1:0]  FIX_LO  = 12'hFE6,
  parameter logic [MB_W-1:0]  FIX_HI  = 12'hFE6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [SRC_W-1:0]  req_src_i,
  input logic [MB_W-1:0]   tolm_i,
  input logic              cfgwin_en_i,
  input logic              dest_valid_o,
  input logic [DEST_W-1:0] dest_o
);
  logic [MB_W-1:0] mb;
  logic fix_a, chip_a, pass_a;
  assign mb     = req_addr_i[ADDR_W-1:GRAN_W];
  assign fix_a  = (mb >= FIX_LO) && (mb <= FIX_HI);
  assign chip_a = (mb >= CHIP_LO) && (mb <= CHIP_HI);
  assign pass_a = (mb > CHIP_HI) || ((mb < tolm_i) && (mb < CHIP_LO));

  p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> dest_valid_o);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !dest_valid_o);
  p_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !dest_valid_o |-> (dest_o == '0));
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    dest_valid_o |-> ($countones(dest_o) == 1));
  p_fix_cpu_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !cfgwin_en_i && fix_a && req_src_i == CPU_SRC) |=> dest_o[D_LOC]);
  p_fix_other_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !cfgwin_en_i && fix_a && req_src_i != CPU_SRC) |=> dest_o[D_ABT]);
  p_chip_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !cfgwin_en_i && chip_a && !fix_a) |=> dest_o[D_ABT]);
  p_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !cfgwin_en_i && pass_a) |=> dest_o[D_PASS]);
endmodule

bind mmio_lo_router mmio_lo_router_chk #(
  .SRC_W(SRC_W), .CPU_SRC(CPU_SRC), .CHIP_LO(CHIP_LO), .CHIP_HI(CHIP_HI),
  .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)
) u_chk (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_src_i(req_src_i), .tolm_i(tolm_i), .cfgwin_en_i(cfgwin_en_i),
  .dest_valid_o(dest_valid_o), .dest_o(dest_o)
);

// File: tb/tb_mmio_lo_router.sv
`timescale 1ns/1ps
module tb_mmio_lo_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_src_i = '0;
  logic [11:0] tolm_i = 12'h800;
  logic [71:0] mem_base_i, mem_limit_i, pf_base_i, pf_limit_i;
  logic [5:0]  pf_high_i = '0;
  logic        cfgwin_en_i = 1'b0;
  logic [11:0] cfgwin_base_i = 12'hE00;
  logic        dest_valid_o, config_error_o;
  logic [10:0] dest_o;

  logic [11:0] mb_b[6], mb_l[6], pb_b[6], pb_l[6];
  int checks = 0, errors = 0;

  for (genvar p = 0; p < 6; p++) begin : g_flat
    assign mem_base_i[p*12 +: 12]  = mb_b[p];
    assign mem_limit_i[p*12 +: 12] = mb_l[p];
    assign pf_base_i[p*12 +: 12]   = pb_b[p];
    assign pf_limit_i[p*12 +: 12]  = pb_l[p];
  end

  mmio_lo_router dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [10:0] b(input int i);
    return 11'(1) << i;
  endfunction

  task automatic default_cfg();
    for (int p = 0; p < 6; p++) begin
      mb_b[p] = 12'h800 + 12'(p * 'h40);
      mb_l[p] = mb_b[p] + 12'h1F;
      pb_b[p] = mb_b[p] + 12'h20;
      pb_l[p] = mb_b[p] + 12'h3F;
    end
    pf_high_i = '0; cfgwin_en_i = 1'b0; tolm_i = 12'h800;
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_src_i = s;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic chk_dest(input string tag, input logic [10:0] exp);
    checks++;
    if (dest_valid_o !== 1'b1 || dest_o !== exp) begin
      errors++;
      $display("FAIL %s: actual valid=%b dest=%b, expected valid=1 dest=%b",
               tag, dest_valid_o, dest_o, exp);
    end
  endtask

  task automatic chk_err(input string tag, input logic exp);
    @(negedge clk);
    checks++;
    if (config_error_o !== exp) begin
      errors++;
      $display("FAIL %s: actual config_error=%b, expected %b", tag, config_error_o, exp);
    end
  endtask

  task automatic t_reset();
    req_valid_i = 1'b1; req_addr_i = 32'h8000_0000;
    repeat (3) @(negedge clk);
    checks++;
    if (dest_valid_o !== 1'b0 || dest_o !== '0 || config_error_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b/%b/%b, expected 0/0/0",
               dest_valid_o, dest_o, config_error_o);
    end
    req_valid_i = 1'b0; rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dest_valid_o !== 1'b0 || dest_o !== '0) begin
      errors++;
      $display("FAIL R1 idle: actual %b/%b, expected 0/0", dest_valid_o, dest_o);
    end
  endtask

  task automatic t_port_hits();
    for (int p = 0; p < 6; p++) begin
      send({mb_b[p], 20'h0}, 2'd0);        chk_dest("R3 mem base", b(p));
      send({mb_l[p], 20'hFFFFF}, 2'd1);    chk_dest("R3 mem limit", b(p));
      send({pb_b[p] + 12'h5, 20'h12345}, 2'd0); chk_dest("R3 pf", b(p));
    end
    chk_err("R10 clean config", 1'b0);
  endtask

  task automatic t_disabled();
    mb_l[0] = 12'h7FF;
    send(32'h8000_0000, 2'd0); chk_dest("R3 disabled window", b(6));
    mb_l[0] = 12'h81F;
  endtask

  task automatic t_pf_high();
    pf_high_i[1] = 1'b1;
    send({pb_b[1], 20'h0}, 2'd0); chk_dest("R4 pf relocated", b(6));
    send({mb_b[1], 20'h0}, 2'd0); chk_dest("R4 mem stays", b(1));
    pf_high_i[1] = 1'b0;
  endtask

  task automatic t_subtractive();
    send(32'h9800_0000, 2'd0); chk_dest("R5 miss above ports", b(6));
    send(32'hFDFF_FFFF, 2'd0); chk_dest("R5 band top", b(6));
  endtask

  task automatic t_fixed();
    send(32'hFE60_0000, 2'd0); chk_dest("R6 fixed cpu low", b(7));
    send(32'hFE6F_FFFF, 2'd0); chk_dest("R6 fixed cpu high", b(7));
    send(32'hFE64_0000, 2'd2); chk_dest("R6 fixed other src", b(9));
  endtask

  task automatic t_chip_abort();
    send(32'hFE00_0000, 2'd0); chk_dest("R7 chip low", b(9));
    send(32'hFEBF_FFFF, 2'd0); chk_dest("R7 chip high", b(9));
    send(32'hFE70_0000, 2'd0); chk_dest("R7 above fixed", b(9));
  endtask

  task automatic t_pass();
    send(32'hFEC0_0000, 2'd0); chk_dest("R9 above chip", b(10));
    send(32'h7FFF_FFFF, 2'd0); chk_dest("R9 below tolm", b(10));
  endtask

  task automatic t_cfgwin();
    cfgwin_en_i = 1'b1;
    send(32'hE012_3456, 2'd0); chk_dest("R8 cfg window", b(8));
    send(32'hEFFF_FFFF, 2'd3); chk_dest("R8 cfg top", b(8));
    send(32'hF000_0000, 2'd0); chk_dest("R8 past cfg", b(6));
    cfgwin_base_i = 12'h840;
    send({mb_b[1], 20'h0}, 2'd0); chk_dest("R8 over port", b(8));
    cfgwin_en_i = 1'b0; cfgwin_base_i = 12'hE00;
    send(32'hE012_3456, 2'd0); chk_dest("R8 cfg off", b(6));
  endtask

  task automatic t_overlap();
    pb_l[1] = 12'h885;
    chk_err("R10 overlap", 1'b1);
    send(32'h8830_0000, 2'd0); chk_dest("R12 priority", b(1));
    pf_high_i[1] = 1'b1;
    chk_err("R4 relocated pf no overlap", 1'b0);
    send(32'h8830_0000, 2'd0); chk_dest("R12 next window", b(2));
    pf_high_i[1] = 1'b0; pb_l[1] = 12'h87F;
    chk_err("R10 restored", 1'b0);
  endtask

  task automatic t_outband();
    mb_b[0] = 12'h7F0;
    chk_err("R11 base below tolm", 1'b1);
    mb_b[0] = 12'h800; pb_l[5] = 12'hFE0;
    chk_err("R11 limit in chip region", 1'b1);
    pb_l[5] = 12'h97F;
    chk_err("R11 restored", 1'b0);
  endtask

  initial begin
    default_cfg();
    t_reset();
    t_port_hits();
    t_disabled();
    t_pf_high();
    t_subtractive();
    t_fixed();
    t_chip_abort();
    t_pass();
    t_cfgwin();
    t_overlap();
    t_outband();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule